// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a real-time clock that shows its time and date as the eight highest bytes of a byte-wide, synchronous, SRAM-like address space. Every other address reaches a small behavioural memory that stands in for a general-purpose array. A one-pulse-per-second strobe advances a set of live BCD counters: seconds, minutes, 24-hour hours, day of week, date, month and two-digit year. Month lengths, including February in leap years, are handled in hardware.

Software never touches the live counters directly on a read. It reads a bank of holding registers. These registers are reloaded from the counters, all at once, in the clock cycle after each strobe. A freeze bit in the control byte stops that reload, so a multi-byte read cannot catch a carry in mid-flight. Timekeeping carries on underneath. A write to a time byte sets the matching live counter, and the new value becomes visible at the next reload.

Top module: `bcd_rtc_map`

## Requirements
- R1: Addresses whose bits above bit 2 are all 1 form the clock window. Offsets 0 to 7 within it are control, seconds, minutes, hours, day of week, date, month and year. Every other address reaches the RAM, which is indexed by the low RAM_AW address bits.
- R2: rdata is combinational. It equals the addressed byte while cs=1, oe=1 and we=0, and it is 8'h00 otherwise.
- R3: A write happens at the rising clock edge while cs=1 and we=1. A write to a time byte loads the live counter for that byte, with the unused bits cleared. The holding register for that byte is not changed by the write.
- R4: A tick advances the seconds in BCD. The seconds carry into minutes at 59, the minutes carry into hours at 59, and the hours wrap from 23 to 00. Each hour wrap advances the day of week, which runs 1 to 7 and wraps from 7 to 1.
- R5: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other non-February months. The month wraps from 12 to 01, which advances the year, and the year wraps from 99 to 00.
- R6: February ends at day 29 when the BCD year, read as a two-digit number, is divisible by 4, and at day 28 otherwise.
- R7: In the cycle after a tick, and only while the freeze bit is 0, all seven holding registers are loaded together from the live counters.
- R8: The freeze bit is bit 6 of the control byte. While it is 1, the holding registers keep their values and the live counters keep counting. After the bit is cleared, the holding registers stay as they are until the reload that follows the next tick.
- R9: A write that sets the freeze bit in the same cycle as a reload does not cancel that reload.
- R10: Unused bits read as 0. The usable widths are: control bit 6 only, seconds and minutes 7 bits, hours and date 6 bits, day 3 bits, month 5 bits, year 8 bits. After reset the clock reads 00:00:00, day 1, date 01, month 01, year 00, with the freeze bit at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| rdata | output | 8 | Read data, 0 when no read is enabled |

## Verification
The bench builds the block with ADDR_W=15 and RAM_AW=6. A 64-byte array lets the RAM be written and read both at the bottom of the space and just below the clock window, while the window decode still sees the full 15-bit address. The bench writes the last second of 28 February in a leap and in a non-leap year, of 30 April and of 31 December 99, then drives single strobes across each rollover. It places a freeze write on the exact reload cycle, and it lets strobes pass while frozen to show that the hidden counters kept running.

// File: rtl/rtc_pkg.sv
// Shared constants and BCD helpers for the calendar clock.
// Assumes all counter values handled are valid packed BCD.
package rtc_pkg;
    localparam int NUM_TIME = 7;   // seconds .. year
    localparam int FREEZE_BIT = 6; // bit of the control byte

    // Writable bits of each window byte, indexed by window offset.
    function automatic logic [7:0] field_mask(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h40;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h7F;
            3'd3:    return 8'h3F;
            3'd4:    return 8'h07;
            3'd5:    return 8'h3F;
            3'd6:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Two-digit BCD increment, 99 wraps to 00.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            if (v[7:4] >= 4'd9) return 8'h00;
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two-digit BCD year divisible by 4.
    function automatic logic is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last date of a BCD month.
    function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_ram.sv
// Behavioural byte memory for the space below the clock window.
// Synchronous write, combinational read, no reset of contents.
module rtc_ram #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[waddr] <= wdata;
    end

    assign rdata = mem[waddr];
endmodule

// File: rtl/rtc_counters.sv
// Live BCD time and date counters advanced by the one-second tick.
// A user write to a field overrides the tick result for that field.
// Assumes written values are valid BCD within range.
module rtc_counters
    import rtc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [NUM_TIME-1:0]        fld_wr,
    input  logic [7:0]                 wdata,
    output logic [NUM_TIME-1:0][7:0]   live
);
    logic [7:0] sec, min, hr, dow, date, mon, yr;
    logic [7:0] last_day;

    assign last_day = month_last(mon, is_leap(yr));

    // Carry chain on tick, then per-field user loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec  <= 8'h00;
            min  <= 8'h00;
            hr   <= 8'h00;
            dow  <= 8'h01;
            date <= 8'h01;
            mon  <= 8'h01;
            yr   <= 8'h00;
        end else begin
            if (tick) begin
                if (sec != 8'h59) sec <= bcd_inc(sec);
                else begin
                    sec <= 8'h00;
                    if (min != 8'h59) min <= bcd_inc(min);
                    else begin
                        min <= 8'h00;
                        if (hr != 8'h23) hr <= bcd_inc(hr);
                        else begin
                            hr  <= 8'h00;
                            dow <= (dow >= 8'h07) ? 8'h01 : dow + 8'h01;
                            if (date != last_day) date <= bcd_inc(date);
                            else begin
                                date <= 8'h01;
                                if (mon != 8'h12) mon <= bcd_inc(mon);
                                else begin
                                    mon <= 8'h01;
                                    yr  <= bcd_inc(yr);
                                end
                            end
                        end
                    end
                end
            end
            if (fld_wr[0]) sec  <= wdata & field_mask(3'd1);
            if (fld_wr[1]) min  <= wdata & field_mask(3'd2);
            if (fld_wr[2]) hr   <= wdata & field_mask(3'd3);
            if (fld_wr[3]) dow  <= wdata & field_mask(3'd4);
            if (fld_wr[4]) date <= wdata & field_mask(3'd5);
            if (fld_wr[5]) mon  <= wdata & field_mask(3'd6);
            if (fld_wr[6]) yr   <= wdata & field_mask(3'd7);
        end
    end

    assign live = {yr, mon, date, dow, hr, min, sec};
endmodule

// File: rtl/rtc_holding.sv
// User-visible holding registers and the freeze control bit.
// Reloads every time field together the cycle after a tick unless frozen.
// The freeze value used is the one held before the current edge.
module rtc_holding
    import rtc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       ctrl_wr,
    input  logic [7:0]                 wdata,
    input  logic [NUM_TIME-1:0][7:0]   live,
    output logic [NUM_TIME-1:0][7:0]   hold,
    output logic                       freeze_q,
    output logic                       load_q
);
    logic reload;

    // Delay the tick so the reload sees the advanced counters.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= tick;
    end

    // Freeze bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)       freeze_q <= 1'b0;
        else if (ctrl_wr) freeze_q <= wdata[FREEZE_BIT];
    end

    assign reload = load_q && !freeze_q;

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_hold
        localparam logic [7:0] RST_VAL = (i == 3 || i == 4 || i == 5) ? 8'h01 : 8'h00;
        // One holding byte, loaded on reload.
        always_ff @(posedge clk) begin
            if (!rst_n)      hold[i] <= RST_VAL;
            else if (reload) hold[i] <= live[i];
        end
    end
endmodule

// File: rtl/bcd_rtc_map.sv
// Top: address decode between the clock window and the RAM, read mux.
// Assumes single-cycle synchronous bus accesses; reads are combinational.
module bcd_rtc_map
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              cs,
    input  logic              we,
    input  logic              oe,
    output logic [7:0]        rdata
);
    logic                      in_win;
    logic [2:0]                offs;
    logic                      wr, rd;
    logic [NUM_TIME-1:0]       fld_wr;
    logic                      ctrl_wr;
    logic [NUM_TIME-1:0][7:0]  live, hold;
    logic                      freeze_q, load_q;
    logic [7:0]                ram_q, win_q;
    logic [7:0]                live_sec, hold_sec;
    logic                      sec_wr;

    assign in_win  = &addr[ADDR_W-1:3];
    assign offs    = addr[2:0];
    assign wr      = cs && we;
    assign rd      = cs && oe && !we;
    assign ctrl_wr = wr && in_win && (offs == 3'd0);

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_dec
        assign fld_wr[i] = wr && in_win && (offs == 3'(i + 1));
    end

    rtc_counters u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
        .fld_wr(fld_wr), .wdata(wdata), .live(live)
    );

    rtc_holding u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .ctrl_wr(ctrl_wr),
        .wdata(wdata), .live(live), .hold(hold),
        .freeze_q(freeze_q), .load_q(load_q)
    );

    rtc_ram #(.AW(RAM_AW)) u_ram (
        .clk(clk), .wr_en(wr && !in_win), .waddr(addr[RAM_AW-1:0]),
        .wdata(wdata), .rdata(ram_q)
    );

    // Window byte select.
    always_comb begin
        if (offs == 3'd0) win_q = {1'b0, freeze_q, 6'b0};
        else              win_q = hold[offs - 3'd1];
    end

    assign rdata = rd ? (in_win ? win_q : ram_q) : 8'h00;

    assign live_sec = live[0];
    assign hold_sec = hold[0];
    assign sec_wr   = fld_wr[0];
endmodule

// File: rtl/rtc_checker.sv
// Property checker for bcd_rtc_map, attached by bind.
module rtc_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              cs,
    input logic              we,
    input logic              oe,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              freeze_q,
    input logic              load_q,
    input logic [7:0]        live_sec,
    input logic [7:0]        hold_sec,
    input logic              sec_wr
);
    assert_live_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sec_wr) |=> $stable(live_sec));

    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sec_wr && live_sec == 8'h59) |=> (live_sec == 8'h00));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q && !freeze_q) |=> (hold_sec == $past(live_sec)));

    assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_q |=> $stable(hold_sec));

    assert_ctrl_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && oe && !we && (addr == {ADDR_W{1'b1}} - ADDR_W'(7))) |-> ((rdata & 8'hBF) == 8'h00));
endmodule

bind bcd_rtc_map rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .cs(cs), .we(we), .oe(oe),
    .addr(addr), .rdata(rdata), .freeze_q(freeze_q), .load_q(load_q),
    .live_sec(live_sec), .hold_sec(hold_sec), .sec_wr(sec_wr)
);

// File: tb/bcd_rtc_map_tb.sv
// Scoreboard bench: the driver queues expected bytes, the monitor compares.
module bcd_rtc_map_tb;
    localparam int AW = 15;
    localparam logic [AW-1:0] CTL = 15'h7FF8, SEC = 15'h7FF9, MIN = 15'h7FFA,
        HRS = 15'h7FFB, DAY = 15'h7FFC, DAT = 15'h7FFD, MON = 15'h7FFE, YR = 15'h7FFF;

    logic clk = 0, rst_n = 0, tick = 0, cs = 0, we = 0, oe = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = 0, rdata;
    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t q[$];
    event rd_ev;

    always #2.5 clk = ~clk;

    bcd_rtc_map #(.ADDR_W(AW), .RAM_AW(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .addr(addr), .wdata(wdata),
        .cs(cs), .we(we), .oe(oe), .rdata(rdata)
    );

    // Monitor: compare each queued expectation against the bus.
    initial forever begin
        item_t it;
        @(rd_ev);
        it = q.pop_front();
        checks++;
        if (rdata !== it.exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", it.tag, rdata, it.exp);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; cs = 1; we = 1; oe = 0;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag, input bit en = 1);
        @(negedge clk); addr = a; cs = en; oe = en; we = 0;
        #1; q.push_back('{e, tag}); -> rd_ev;
        #0.5; cs = 0; oe = 0;
    endtask

    task automatic pulse();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] y, m, d, h, mi, s);
        wr(YR, y); wr(MON, m); wr(DAT, d); wr(HRS, h); wr(MIN, mi); wr(SEC, s);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // Reset values
        rd(CTL, 8'h00, "R10 ctrl reset");
        rd(SEC, 8'h00, "R10 sec reset");
        rd(DAY, 8'h01, "R10 day reset");
        rd(DAT, 8'h01, "R10 date reset");
        rd(MON, 8'h01, "R10 month reset");
        // RAM below the window
        wr(15'h0010, 8'hA5); wr(15'h7FF7, 8'h3C);
        rd(15'h0010, 8'hA5, "R1 ram low");
        rd(15'h7FF7, 8'h3C, "R1 ram below window");
        rd(15'h0010, 8'h00, "R2 idle bus", 0);
        // Non-leap end of February, day 7 wraps
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); wr(DAY, 8'h07);
        rd(SEC, 8'h00, "R3 holding untouched by write");
        pulse();
        rd(SEC, 8'h00, "R4 sec wrap");
        rd(MIN, 8'h00, "R4 min wrap");
        rd(HRS, 8'h00, "R4 hour wrap");
        rd(DAY, 8'h01, "R4 dow 7 to 1");
        rd(DAT, 8'h01, "R6 nonleap date");
        rd(MON, 8'h03, "R6 nonleap month");
        rd(YR,  8'h23, "R7 year loaded");
        // Leap February
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        pulse();
        rd(DAT, 8'h29, "R6 leap day 29");
        rd(MON, 8'h02, "R6 leap month");
        rd(DAY, 8'h02, "R4 dow advance");
        wr(HRS, 8'h23); wr(MIN, 8'h59); wr(SEC, 8'h59);
        pulse();
        rd(DAT, 8'h01, "R6 leap end date");
        rd(MON, 8'h03, "R6 leap end month");
        // 30-day month
        set_time(8'h24, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        pulse();
        rd(DAT, 8'h01, "R5 april end date");
        rd(MON, 8'h05, "R5 april end month");
        // Year end
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        pulse();
        rd(DAT, 8'h01, "R5 dec end date");
        rd(MON, 8'h01, "R5 dec end month");
        rd(YR,  8'h00, "R5 year wrap");
        rd(DAY, 8'h05, "R4 dow count");
        // BCD digit carry
        wr(SEC, 8'h09);
        pulse();
        rd(SEC, 8'h10, "R4 bcd carry");
        // Unused bits
        wr(CTL, 8'hBF);
        rd(CTL, 8'h00, "R10 ctrl unused bits");
        wr(DAY, 8'hF3);
        pulse();
        rd(DAY, 8'h03, "R10 day mask");
        rd(SEC, 8'h11, "R7 sec after mask test");
        // Freeze
        wr(CTL, 8'h40);
        rd(CTL, 8'h40, "R8 freeze readback");
        pulse(); pulse(); pulse();
        rd(SEC, 8'h11, "R8 frozen holding");
        wr(CTL, 8'h00);
        rd(SEC, 8'h11, "R8 no refresh before tick");
        pulse();
        rd(SEC, 8'h15, "R8 counters kept running");
        // Freeze written on the reload cycle
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0; addr = CTL; wdata = 8'h40; cs = 1; we = 1;
        @(negedge clk); cs = 0; we = 0;
        rd(SEC, 8'h16, "R9 reload completes");
        pulse();
        rd(SEC, 8'h16, "R8 frozen after R9");
        wr(CTL, 8'h00);
        pulse();
        rd(SEC, 8'h18, "R8 refresh after clear");
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule